// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider with Reference Divider

This block forms the divide chain of a frequency synthesizer loop. On the VCO side it divides the input clock by a total ratio of `PRE_LOW*N + A`. A dual-modulus prescaler model counts periods of either `PRE_LOW+1` or `PRE_LOW` input clocks. A swallow counter decides how many of those periods use the longer modulus, and a main counter decides how many prescaler periods make up one output cycle. Each time an output cycle completes, the block emits a pulse on `fp_pulse` that is one input clock wide.

Software or a serial loader presents a new main count and swallow count and strobes `cfg_load`. The values are held in shadow registers and are adopted at the next output-cycle boundary, so an output cycle is never cut short. A main count below the legal minimum is raised to that minimum, and `n_clamped` stays high until the next load. The reference side runs on a separate oscillator clock. It divides that clock by either `REF_SHORT` or `REF_LONG` and emits `fr_pulse`, and the ratio select is adopted at each reference pulse. With the default parameters (64/65 prescaler, 512/1024 reference ratios) and a 12.8 MHz oscillator, the reference rate is 25 kHz or 12.5 kHz.

Top module: `psw_divider_top`

## Requirements
- R1: While reset is held, `fp_pulse`, `fr_pulse` and `n_clamped` are low. After reset the divider runs with N = `N_MIN` and A = 0, so the first `fp_pulse` appears `PRE_LOW*N_MIN` clocks after the first clock edge following reset release.
- R2: With `N_MIN` <= N and 0 < A < N, successive `fp_pulse` rising samples are exactly `PRE_LOW*N + A` input clocks apart. N is the unsigned binary value on `div_n`, and A is the unsigned binary value on `div_a`.
- R3: With A = 0, every prescaler period uses modulus `PRE_LOW`, and the output period is `PRE_LOW*N` clocks.
- R4: A load with N < `N_MIN` behaves as N = `N_MIN`. `n_clamped` is high in the clock after that load.
- R5: A load with N >= `N_MIN` drives `n_clamped` low in the clock after the load.
- R6: Values loaded during an output cycle do not change that cycle's length. They govern the cycle that starts at the next `fp_pulse`.
- R7: `fp_pulse` is high for exactly one input clock per output cycle.
- R8: When A >= N, every prescaler period of the cycle uses modulus `PRE_LOW+1`, and the output period is `(PRE_LOW+1)*N` clocks.
- R9: With `ref_long` = 0, `fr_pulse` repeats every `REF_SHORT` oscillator clocks. With `ref_long` = 1, it repeats every `REF_LONG` clocks. Each pulse is one clock wide.
- R10: A change on `ref_long` takes effect only for the interval that begins at the next `fr_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Divided input clock (modelled VCO) |
| vco_rst_n | input | 1 | Active-low reset, VCO domain |
| div_n | input | N_W | Main count N, unsigned binary |
| div_a | input | A_W | Swallow count A, unsigned binary |
| cfg_load | input | 1 | Strobe that captures `div_n` and `div_a` |
| fp_pulse | output | 1 | One-clock pulse per output cycle |
| n_clamped | output | 1 | Last load carried N below `N_MIN` |
| osc_clk | input | 1 | Reference oscillator clock |
| osc_rst_n | input | 1 | Active-low reset, oscillator domain |
| ref_long | input | 1 | 1 selects `REF_LONG`, 0 selects `REF_SHORT` |
| fr_pulse | output | 1 | One-clock reference pulse |

## Verification
A fault in the swallow or main counter shows up as a wrong spacing between `fp_pulse` rising samples. The spacing is off by a whole prescaler period when the main count slips, or by one clock per misplaced long period when the swallow count slips. Either error is visible at the first pulse that completes the affected cycle. A shadow register that takes new values too early shows up as a wrong length for the cycle in which the load happened. A bad reference counter shows up as a wrong `fr_pulse` spacing within one interval of the change.

// File: rtl/psw_pkg.sv
package psw_pkg;
   typedef enum logic {
      MOD_LOW  = 1'b0,
      MOD_HIGH = 1'b1
   } psw_mod_e;
endpackage

// File: rtl/psw_cfg.sv
module psw_cfg #(
   parameter int N_W   = 11,
   parameter int A_W   = 7,
   parameter int N_MIN = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   output logic [N_W-1:0] n_sh,
   output logic [A_W-1:0] a_sh,
   output logic           n_low
);
   localparam logic [N_W-1:0] NFLOOR = N_W'(N_MIN);

   logic n_too_small;
   assign n_too_small = (n_in < NFLOOR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_sh  <= NFLOOR;
         a_sh  <= '0;
         n_low <= 1'b0;
      end else if (load) begin
         n_sh  <= n_too_small ? NFLOOR : n_in;
         a_sh  <= a_in;
         n_low <= n_too_small;
      end
   end

   // R4
   n_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      n_sh >= NFLOOR);
   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && n_in < NFLOOR) |=> n_low);
   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(n_sh) && $stable(a_sh)));
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
   import psw_pkg::*;
#(
   parameter int PRE_LOW = 64
) (
   input  logic     clk,
   input  logic     rst_n,
   input  psw_mod_e mod_sel,
   output logic     tick
);
   localparam int PW = $clog2(PRE_LOW + 2);
   localparam logic [PW-1:0] LOAD_HI = PW'(PRE_LOW);
   localparam logic [PW-1:0] LOAD_LO = PW'(PRE_LOW - 1);

   logic [PW-1:0] pc_q;

   assign tick = (pc_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= LOAD_LO;
      else if (tick)
         pc_q <= (mod_sel == MOD_HIGH) ? LOAD_HI : LOAD_LO;
      else
         pc_q <= pc_q - PW'(1);
   end

   // R2
   pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q <= LOAD_HI);
   // R8
   long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q == LOAD_HI) |=> (pc_q == LOAD_LO));
endmodule

// File: rtl/psw_swallow_core.sv
module psw_swallow_core
   import psw_pkg::*;
#(
   parameter int N_W   = 11,
   parameter int A_W   = 7,
   parameter int N_MIN = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [N_W-1:0] n_src,
   input  logic [A_W-1:0] a_src,
   output psw_mod_e       mod_sel,
   output logic           fp
);
   logic [A_W-1:0] sw_q, sw_nx;
   logic [N_W-1:0] mn_q, mn_nx;
   logic           last_period;

   assign last_period = (mn_q == N_W'(1));

   always_comb begin
      sw_nx = sw_q;
      mn_nx = mn_q;
      if (tick) begin
         if (last_period) begin
            sw_nx = a_src;
            mn_nx = n_src;
         end else begin
            mn_nx = mn_q - N_W'(1);
            if (sw_q != '0)
               sw_nx = sw_q - A_W'(1);
         end
      end
      mod_sel = (sw_nx != '0) ? MOD_HIGH : MOD_LOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= '0;
         mn_q <= N_W'(N_MIN);
         fp   <= 1'b0;
      end else begin
         sw_q <= sw_nx;
         mn_q <= mn_nx;
         fp   <= tick && last_period;
      end
   end

   // R7
   fp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fp |=> !fp);
   // R2
   mn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mn_q != '0);
endmodule

// File: rtl/psw_ref_div.sv
module psw_ref_div #(
   parameter int REF_SHORT = 512,
   parameter int REF_LONG  = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_long,
   output logic fr
);
   localparam bit TWICE = (REF_LONG == 2 * REF_SHORT);

   generate
      if (TWICE) begin : g_twice
         localparam int SW = $clog2(REF_SHORT);
         logic [SW-1:0] cnt_q;
         logic          half_q;
         logic          long_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               half_q <= 1'b0;
               long_q <= 1'b0;
               fr     <= 1'b0;
            end else if (cnt_q == '0) begin
               cnt_q <= SW'(REF_SHORT - 1);
               if (long_q && !half_q) begin
                  half_q <= 1'b1;
                  fr     <= 1'b0;
               end else begin
                  half_q <= 1'b0;
                  long_q <= sel_long;
                  fr     <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q - SW'(1);
               fr    <= 1'b0;
            end
         end
      end else begin : g_generic
         localparam int RW = $clog2(REF_LONG);
         logic [RW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               fr    <= 1'b0;
            end else if (cnt_q == '0) begin
               cnt_q <= sel_long ? RW'(REF_LONG - 1) : RW'(REF_SHORT - 1);
               fr    <= 1'b1;
            end else begin
               cnt_q <= cnt_q - RW'(1);
               fr    <= 1'b0;
            end
         end
      end
   endgenerate

   // R9
   fr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fr |=> !fr);
endmodule

// File: rtl/psw_divider_top.sv
module psw_divider_top
   import psw_pkg::*;
#(
   parameter int PRE_LOW   = 64,
   parameter int N_W       = 11,
   parameter int A_W       = 7,
   parameter int N_MIN     = 16,
   parameter int REF_SHORT = 512,
   parameter int REF_LONG  = 1024
) (
   input  logic           vco_clk,
   input  logic           vco_rst_n,
   input  logic [N_W-1:0] div_n,
   input  logic [A_W-1:0] div_a,
   input  logic           cfg_load,
   output logic           fp_pulse,
   output logic           n_clamped,
   input  logic           osc_clk,
   input  logic           osc_rst_n,
   input  logic           ref_long,
   output logic           fr_pulse
);
   generate
      if (PRE_LOW < 2) begin : g_bad_pre
         $error("PRE_LOW must be at least 2");
      end
      if (N_MIN < 1 || N_MIN >= (1 << N_W)) begin : g_bad_nmin
         $error("N_MIN must be nonzero and fit in N_W bits");
      end
      if (REF_SHORT < 2 || REF_LONG <= REF_SHORT) begin : g_bad_ref
         $error("reference ratios must satisfy 2 <= REF_SHORT < REF_LONG");
      end
   endgenerate

   logic [N_W-1:0] n_sh;
   logic [A_W-1:0] a_sh;
   logic           tick;
   psw_mod_e       mod_sel;

   psw_cfg #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_cfg (
      .clk   (vco_clk),
      .rst_n (vco_rst_n),
      .load  (cfg_load),
      .n_in  (div_n),
      .a_in  (div_a),
      .n_sh  (n_sh),
      .a_sh  (a_sh),
      .n_low (n_clamped)
   );

   psw_prescaler #(.PRE_LOW(PRE_LOW)) u_pre (
      .clk     (vco_clk),
      .rst_n   (vco_rst_n),
      .mod_sel (mod_sel),
      .tick    (tick)
   );

   psw_swallow_core #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_core (
      .clk     (vco_clk),
      .rst_n   (vco_rst_n),
      .tick    (tick),
      .n_src   (n_sh),
      .a_src   (a_sh),
      .mod_sel (mod_sel),
      .fp      (fp_pulse)
   );

   psw_ref_div #(.REF_SHORT(REF_SHORT), .REF_LONG(REF_LONG)) u_ref (
      .clk      (osc_clk),
      .rst_n    (osc_rst_n),
      .sel_long (ref_long),
      .fr       (fr_pulse)
   );

   // R7
   fp_needs_tick_chk: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
      $rose(fp_pulse) |-> $past(tick));
endmodule

// File: tb/sim_psw_divider_top.sv
module sim_psw_divider_top;
   localparam int PRE   = 4;
   localparam int NW    = 11;
   localparam int AW    = 7;
   localparam int NMIN  = 4;
   localparam int RSH   = 8;
   localparam int RLG   = 16;
   localparam int LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] div_n = '0;
   logic [AW-1:0] div_a = '0;
   logic          cfg_load = 1'b0;
   logic          ref_long = 1'b0;
   logic          fp_pulse, n_clamped, fr_pulse;

   int total = 0;
   int bad = 0;
   int prev_ratio;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   psw_divider_top #(.PRE_LOW(PRE), .N_W(NW), .A_W(AW), .N_MIN(NMIN),
                     .REF_SHORT(RSH), .REF_LONG(RLG)) u0 (
      .vco_clk(clk), .vco_rst_n(rst_n), .div_n(div_n), .div_a(div_a),
      .cfg_load(cfg_load), .fp_pulse(fp_pulse), .n_clamped(n_clamped),
      .osc_clk(clk), .osc_rst_n(rst_n), .ref_long(ref_long), .fr_pulse(fr_pulse)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_ratio(input int n, input int a);
      int ne = (n < NMIN) ? NMIN : n;
      int hi = (a < ne) ? a : ne;
      return PRE * ne + hi;
   endfunction

   task automatic count_fp(inout int c);
      do begin
         @(negedge clk);
         c++;
      end while (!fp_pulse && c < LIMIT);
   endtask

   task automatic count_fr(output int c);
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!fr_pulse && c < LIMIT);
   endtask

   // Called at the negedge where fp_pulse was just seen high.
   task automatic load_and_check(input int n, input int a);
      int c;
      int er;
      div_n = NW'(n);
      div_a = AW'(a);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      c = 1;
      if (n < NMIN) chk("R4 flag", int'(n_clamped), 1);
      else          chk("R5 flag", int'(n_clamped), 0);
      chk("R7 width", int'(fp_pulse), 0);
      count_fp(c);
      chk("R6 old cycle kept", c, prev_ratio);
      er = exp_ratio(n, a);
      c = 0;
      count_fp(c);
      if (n < NMIN)        chk("R4 ratio", c, er);
      else if (a == 0)     chk("R3 ratio", c, er);
      else if (a >= n)     chk("R8 ratio", c, er);
      else                 chk("R2 ratio", c, er);
      prev_ratio = er;
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      chk("R1 fp in reset", int'(fp_pulse), 0);
      chk("R1 fr in reset", int'(fr_pulse), 0);
      chk("R1 flag in reset", int'(n_clamped), 0);
      rst_n = 1'b1;
      c = 0;
      count_fp(c);
      chk("R1 first period", c, PRE * NMIN);
      prev_ratio = PRE * NMIN;

      for (int n = NMIN; n <= 9; n++)
         for (int a = 0; a <= n + 1; a++)
            load_and_check(n, a);
      load_and_check(2, 1);
      load_and_check(0, 0);
      load_and_check(6, 5);
      load_and_check(2047, 127);
      load_and_check(200, 0);

      // reference divider
      ref_long = 1'b0;
      count_fr(c);
      count_fr(c);
      chk("R9 short", c, RSH);
      ref_long = 1'b1;
      count_fr(c);
      chk("R10 short kept", c, RSH);
      count_fr(c);
      chk("R9 long", c, RLG);
      count_fr(c);
      chk("R9 long repeat", c, RLG);
      ref_long = 1'b0;
      @(negedge clk);
      chk("R9 fr width", int'(fr_pulse), 0);
      c = 1;
      do begin
         @(negedge clk);
         c++;
      end while (!fr_pulse && c < LIMIT);
      chk("R10 long kept", c, RLG);
      count_fr(c);
      chk("R9 short again", c, RSH);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule